// File: doc/BRIEF.md
# Ring Manager Global Configuration and Error Capture Registers

This block holds the chip-wide settings of a DMA queue manager and logs the bus errors that the ring datapath reports. Software reaches it through a simple request port. A request counts only when the region-select input is low. The block holds three things: a trace setup (enable, every-queue or single-queue, message data or operation only, and the queue number), the queue that receives overflow messages, and the event number used to report bus errors. These settings drive output pins that the trace and overflow logic nearby read directly.

The ring datapath reports a bus error as a one-cycle pulse. The pulse carries a queue number and a flag that tells a push from a pop. The block keeps the first such error. It sends a single-cycle event strobe tagged with the programmed event number and raises a level pending flag. Further errors are dropped until software reads the error log word. That read ends the pending state but leaves the logged fields in place.

Top module: `ringmgr_gcfg`

## Requirements
- R1: A request with `req_sel` high is ignored: no response pulse and no change to any register.
- R2: Offset 0x00 reads 0x663C9900: bits 31:16 module code 0x663C, 15:11 RTL revision 0x13, 10:8 major 1, 7:6 custom 0, 5:0 minor 0.
- R3: Offset 0x10 holds trace setup, all zero after reset. Bit 31 is enable, bit 30 selects every queue (1) or the single queue (0), bit 29 adds message data (1), and bits 15:0 give the single queue. These fields drive the trace outputs. Bits 28:16 read 0.
- R4: Offset 0x20 holds the overflow queue in bits 15:0. It resets to 0, drives `ovf_queue`, and its upper bits read 0.
- R5: Offset 0x40 holds the error event number in bits 15:0 and resets to 0xFFFF.
- R6: Every selected request, read or write, gets a one-cycle `rsp_valid` pulse in the cycle after the request. Read data is presented with that pulse. Unlisted offsets read 0.
- R7: Writes to offset 0x00, to offset 0x44 or to an unlisted offset have no effect.
- R8: An error pulse while nothing is pending is captured. From the next cycle `err_pending` is high, and offset 0x44 reads bit 31 = push flag (1 push, 0 pop), bits 15:0 = queue, and the other bits 0.
- R9: A capture produces exactly one cycle of `evt_valid`, in the cycle after the error pulse. `evt_num` then equals the event number programmed at the time of the error.
- R10: Error pulses that arrive while an error is pending are dropped. They change neither the log nor the pending flag, and they produce no event.
- R11: A read of offset 0x44 returns the log and clears `err_pending` from the next cycle. A later read returns the same logged fields.
- R12: An error pulse in the same cycle as a clearing read of the log is captured as a new error. The read returns the old log, `err_pending` stays high and `evt_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_sel | input | 1 | Region select; the block answers only when 0 |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Acknowledge, one cycle after a selected request |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| trace_en | output | 1 | Trace enable |
| trace_all | output | 1 | Trace every queue |
| trace_msg | output | 1 | Include message data in trace |
| trace_queue | output | 16 | Single queue to trace |
| ovf_queue | output | 16 | Overflow destination queue |
| err_valid | input | 1 | Bus error pulse from the datapath |
| err_push | input | 1 | Failing access was a push |
| err_queue | input | 16 | Queue that saw the error |
| err_pending | output | 1 | A captured error awaits a log read |
| evt_valid | output | 1 | Single-cycle error event strobe |
| evt_num | output | 16 | Event number sent with the strobe |

## Verification
The capture logic is driven with four error patterns. A lone error on an idle log checks the capture, the strobe and the field layout, and it separates a push from a pop. A second error while one is pending must leave the log untouched, which shows that only the first error is kept. An error in the same cycle as the clearing read shows that the acknowledge does not swallow a new error. A read after a clear shows that the read drops only the pending state and leaves the fields. The register side is tried with all-ones and with mixed write patterns, so that reserved bits and each trace flag are seen apart. Deselected and reserved-offset accesses are also sent, to show that they leave every setting as it was.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
  localparam int unsigned DATA_W = 32;

  // Byte offsets used by the request decoder.
  localparam logic [7:0] OFS_REV   = 8'h00;
  localparam logic [7:0] OFS_TRACE = 8'h10;
  localparam logic [7:0] OFS_OVF   = 8'h20;
  localparam logic [7:0] OFS_EVT   = 8'h40;
  localparam logic [7:0] OFS_LOG   = 8'h44;

  // Bit positions of the trace flags inside the trace word.
  localparam int unsigned TR_EN_BIT  = 31;
  localparam int unsigned TR_ALL_BIT = 30;
  localparam int unsigned TR_MSG_BIT = 29;
  localparam int unsigned LOG_PUSH_BIT = 31;

  typedef struct packed {
    logic en;
    logic all_q;
    logic msg;
  } trace_flags_t;
endpackage

// File: rtl/gcfg_regs.sv
module gcfg_regs
  import gcfg_pkg::*;
#(
  parameter int unsigned QW = 16,
  parameter logic [QW-1:0] EVT_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_trace,
  input  logic              wr_ovf,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wdata,
  output trace_flags_t      trace_flags,
  output logic [QW-1:0]     trace_q,
  output logic [QW-1:0]     ovf_q,
  output logic [QW-1:0]     evt_cfg
);
  trace_flags_t  flags_d;
  logic [QW-1:0] trace_q_d, ovf_q_d, evt_cfg_d;

  always_comb begin
    flags_d   = trace_flags;
    trace_q_d = trace_q;
    ovf_q_d   = ovf_q;
    evt_cfg_d = evt_cfg;
    if (wr_trace) begin
      flags_d.en    = wdata[TR_EN_BIT];
      flags_d.all_q = wdata[TR_ALL_BIT];
      flags_d.msg   = wdata[TR_MSG_BIT];
      trace_q_d     = wdata[QW-1:0];
    end
    if (wr_ovf) ovf_q_d   = wdata[QW-1:0];
    if (wr_evt) evt_cfg_d = wdata[QW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_flags <= '0;
      trace_q     <= '0;
      ovf_q       <= '0;
      evt_cfg     <= EVT_RESET;
    end else begin
      if (wr_trace) begin
        trace_flags <= flags_d;
        trace_q     <= trace_q_d;
      end
      if (wr_ovf) ovf_q   <= ovf_q_d;
      if (wr_evt) evt_cfg <= evt_cfg_d;
    end
  end

  // R7/R4: overflow queue only moves on its own write strobe
  a_r4_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ovf |=> $stable(ovf_q));
endmodule

// File: rtl/gcfg_errlog.sv
module gcfg_errlog #(
  parameter int unsigned QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_valid,
  input  logic          err_push,
  input  logic [QW-1:0] err_queue,
  input  logic          clear_rd,
  input  logic [QW-1:0] evt_cfg,
  output logic          pending,
  output logic          log_push,
  output logic [QW-1:0] log_queue,
  output logic          evt_valid,
  output logic [QW-1:0] evt_num
);
  logic capture;
  logic pending_d;

  always_comb begin
    capture   = err_valid && (!pending || clear_rd);
    pending_d = pending;
    if (capture)       pending_d = 1'b1;
    else if (clear_rd) pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      log_push  <= 1'b0;
      log_queue <= '0;
      evt_valid <= 1'b0;
      evt_num   <= '0;
    end else begin
      pending   <= pending_d;
      evt_valid <= capture;
      if (capture) begin
        log_push  <= err_push;
        log_queue <= err_queue;
        evt_num   <= evt_cfg;
      end
    end
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !pending) |=> (pending && evt_valid));
  a_r9_evt_pending: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> pending);
  a_r10_drop_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear_rd) |=> (pending && !evt_valid && $stable(log_queue) && $stable(log_push)));
  a_r11_clear_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clear_rd && !err_valid) |=> (!pending && $stable(log_queue) && $stable(log_push)));
  a_r12_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && clear_rd && err_valid) |=> (pending && evt_valid));
endmodule

// File: rtl/ringmgr_gcfg.sv
module ringmgr_gcfg
  import gcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned QW      = 16,
  parameter logic [15:0] MOD_ID  = 16'h663C,
  parameter logic [4:0]  REV_RTL = 5'h13,
  parameter logic [2:0]  REV_MAJ = 3'h1,
  parameter logic [1:0]  REV_CUS = 2'h0,
  parameter logic [5:0]  REV_MIN = 6'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sel,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              trace_en,
  output logic              trace_all,
  output logic              trace_msg,
  output logic [QW-1:0]     trace_queue,
  output logic [QW-1:0]     ovf_queue,
  input  logic              err_valid,
  input  logic              err_push,
  input  logic [QW-1:0]     err_queue,
  output logic              err_pending,
  output logic              evt_valid,
  output logic [QW-1:0]     evt_num
);
  localparam logic [DATA_W-1:0] REV_WORD = {MOD_ID, REV_RTL, REV_MAJ, REV_CUS, REV_MIN};

  logic              acc, rd, wr;
  logic              hit_rev, hit_trace, hit_ovf, hit_evt, hit_log;
  logic [DATA_W-1:0] rdata_d;
  trace_flags_t      flags;
  logic [QW-1:0]     evt_cfg, log_queue;
  logic              log_push;

  always_comb begin
    acc       = req_valid && !req_sel;
    rd        = acc && !req_write;
    wr        = acc && req_write;
    hit_rev   = (req_addr == ADDR_W'(OFS_REV));
    hit_trace = (req_addr == ADDR_W'(OFS_TRACE));
    hit_ovf   = (req_addr == ADDR_W'(OFS_OVF));
    hit_evt   = (req_addr == ADDR_W'(OFS_EVT));
    hit_log   = (req_addr == ADDR_W'(OFS_LOG));
  end

  gcfg_regs #(.QW(QW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_trace   (wr && hit_trace),
    .wr_ovf     (wr && hit_ovf),
    .wr_evt     (wr && hit_evt),
    .wdata      (req_wdata),
    .trace_flags(flags),
    .trace_q    (trace_queue),
    .ovf_q      (ovf_queue),
    .evt_cfg    (evt_cfg)
  );

  gcfg_errlog #(.QW(QW)) u_errlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_valid(err_valid),
    .err_push (err_push),
    .err_queue(err_queue),
    .clear_rd (rd && hit_log),
    .evt_cfg  (evt_cfg),
    .pending  (err_pending),
    .log_push (log_push),
    .log_queue(log_queue),
    .evt_valid(evt_valid),
    .evt_num  (evt_num)
  );

  always_comb begin
    trace_en  = flags.en;
    trace_all = flags.all_q;
    trace_msg = flags.msg;
    rdata_d   = '0;
    if (hit_rev) rdata_d = REV_WORD;
    if (hit_trace) begin
      rdata_d              = DATA_W'(trace_queue);
      rdata_d[TR_EN_BIT]   = flags.en;
      rdata_d[TR_ALL_BIT]  = flags.all_q;
      rdata_d[TR_MSG_BIT]  = flags.msg;
    end
    if (hit_ovf) rdata_d = DATA_W'(ovf_queue);
    if (hit_evt) rdata_d = DATA_W'(evt_cfg);
    if (hit_log) begin
      rdata_d               = DATA_W'(log_queue);
      rdata_d[LOG_PUSH_BIT] = log_push;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      if (rd) rsp_rdata <= rdata_d;
      else if (acc) rsp_rdata <= '0;
    end
  end

  a_r6_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  a_r1_no_rsp_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_sel) |=> !rsp_valid);
  a_r1_cfg_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel) |=> ($stable(trace_queue) && $stable(evt_cfg)));
endmodule

// File: tb/tb_ringmgr_gcfg.sv
module tb_ringmgr_gcfg;
  logic        clk, rst_n;
  logic        req_valid, req_sel, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        trace_en, trace_all, trace_msg;
  logic [15:0] trace_queue, ovf_queue;
  logic        err_valid, err_push;
  logic [15:0] err_queue;
  logic        err_pending, evt_valid;
  logic [15:0] evt_num;

  int total = 0;
  int bad = 0;

  ringmgr_gcfg dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .trace_en(trace_en),
    .trace_all(trace_all), .trace_msg(trace_msg), .trace_queue(trace_queue),
    .ovf_queue(ovf_queue), .err_valid(err_valid), .err_push(err_push),
    .err_queue(err_queue), .err_pending(err_pending), .evt_valid(evt_valid),
    .evt_num(evt_num)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; returns whether it was acknowledged and the data.
  task automatic access(input logic sel, input logic wr, input logic [7:0] a,
                        input logic [31:0] d, output logic ok, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_sel = 1'b0; req_write = 1'b0;
    ok = rsp_valid; q = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic ok; logic [31:0] q;
    access(1'b0, 1'b0, a, 32'h0, ok, q);
    check(req, {31'b0, ok}, 32'h1);
    check(req, q, exp);
  endtask

  task automatic wr_do(input logic [7:0] a, input logic [31:0] d);
    logic ok; logic [31:0] q;
    access(1'b0, 1'b1, a, d, ok, q);
  endtask

  task automatic inject(input logic p, input logic [15:0] qn,
                        output logic ev, output logic pend, output logic [15:0] num);
    @(negedge clk);
    err_valid = 1'b1; err_push = p; err_queue = qn;
    @(negedge clk);
    err_valid = 1'b0;
    ev = evt_valid; pend = err_pending; num = evt_num;
  endtask

  task automatic t_reset;
    check("R3 reset trace_en", {31'b0, trace_en}, 32'h0);
    check("R3 reset trace_queue", {16'b0, trace_queue}, 32'h0);
    check("R4 reset ovf_queue", {16'b0, ovf_queue}, 32'h0);
    check("R8 reset pending", {30'b0, err_pending, evt_valid}, 32'h0);
    check("R6 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rd_chk("R3 reset trace read", 8'h10, 32'h0);
    rd_chk("R4 reset ovf read", 8'h20, 32'h0);
    rd_chk("R5 reset event read", 8'h40, 32'h0000FFFF);
  endtask

  task automatic t_revision;
    rd_chk("R2 revision", 8'h00, 32'h663C9900);
    wr_do(8'h00, 32'hFFFFFFFF);
    rd_chk("R7 revision after write", 8'h00, 32'h663C9900);
  endtask

  task automatic t_trace;
    wr_do(8'h10, 32'hFFFFFFFF);
    rd_chk("R3 trace all ones", 8'h10, 32'hE000FFFF);
    check("R3 flags all ones", {29'b0, trace_en, trace_all, trace_msg}, 32'h7);
    wr_do(8'h10, 32'hA0001234);
    rd_chk("R3 trace mixed", 8'h10, 32'hA0001234);
    check("R3 flags mixed", {29'b0, trace_en, trace_all, trace_msg}, 32'h5);
    check("R3 trace queue", {16'b0, trace_queue}, 32'h1234);
  endtask

  task automatic t_ovf_and_ignore;
    logic ok; logic [31:0] q;
    wr_do(8'h20, 32'hABCD5678);
    rd_chk("R4 ovf read", 8'h20, 32'h00005678);
    check("R4 ovf out", {16'b0, ovf_queue}, 32'h5678);
    access(1'b1, 1'b1, 8'h20, 32'h00001111, ok, q);
    check("R1 no ack on deselected write", {31'b0, ok}, 32'h0);
    check("R1 ovf unchanged", {16'b0, ovf_queue}, 32'h5678);
    access(1'b1, 1'b0, 8'h00, 32'h0, ok, q);
    check("R1 no ack on deselected read", {31'b0, ok}, 32'h0);
  endtask

  task automatic t_reserved;
    logic ok; logic [31:0] q;
    access(1'b0, 1'b1, 8'h30, 32'hFFFFFFFF, ok, q);
    check("R6 write ack", {31'b0, ok}, 32'h1);
    @(negedge clk);
    check("R6 ack is one cycle", {31'b0, rsp_valid}, 32'h0);
    rd_chk("R7 reserved offset reads 0", 8'h30, 32'h0);
    check("R7 settings untouched", {16'b0, ovf_queue}, 32'h5678);
  endtask

  task automatic t_first_error;
    logic ev, pend; logic [15:0] num;
    wr_do(8'h40, 32'h00000042);
    inject(1'b1, 16'h0007, ev, pend, num);
    check("R8 pending after capture", {31'b0, pend}, 32'h1);
    check("R9 strobe", {31'b0, ev}, 32'h1);
    check("R9 event number", {16'b0, num}, 32'h0042);
    @(negedge clk);
    check("R9 strobe single cycle", {31'b0, evt_valid}, 32'h0);
    rd_chk("R8 log push word", 8'h44, 32'h80000007);
    check("R11 pending cleared", {31'b0, err_pending}, 32'h0);
    rd_chk("R11 log fields kept", 8'h44, 32'h80000007);
  endtask

  task automatic t_drop;
    logic ev, pend; logic [15:0] num;
    inject(1'b0, 16'h0011, ev, pend, num);
    check("R8 pop captured", {31'b0, pend}, 32'h1);
    inject(1'b1, 16'h0022, ev, pend, num);
    check("R10 no strobe while pending", {31'b0, ev}, 32'h0);
    check("R10 still pending", {31'b0, pend}, 32'h1);
    rd_chk("R10 log keeps first", 8'h44, 32'h00000011);
  endtask

  task automatic t_same_cycle;
    logic ev, pend; logic [15:0] num;
    inject(1'b1, 16'h0033, ev, pend, num);
    @(negedge clk);
    req_valid = 1'b1; req_sel = 1'b0; req_write = 1'b0; req_addr = 8'h44;
    err_valid = 1'b1; err_push = 1'b0; err_queue = 16'h0044;
    @(negedge clk);
    req_valid = 1'b0; err_valid = 1'b0;
    check("R12 read returns old log", rsp_rdata, 32'h80000033);
    check("R12 stays pending", {31'b0, err_pending}, 32'h1);
    check("R12 new strobe", {31'b0, evt_valid}, 32'h1);
    wr_do(8'h44, 32'hFFFFFFFF);
    check("R7 log write keeps pending", {31'b0, err_pending}, 32'h1);
    rd_chk("R12 new error logged", 8'h44, 32'h00000044);
    check("R11 cleared after read", {31'b0, err_pending}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_sel = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    err_valid = 1'b0; err_push = 1'b0; err_queue = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revision();
    t_trace();
    t_ovf_and_ignore();
    t_reserved();
    t_first_error();
    t_drop();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule